// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This block collects completion events from two groups of DMA channels, a normal group and a dedicated group, into one status word. Every channel gives two single-cycle pulses: one when half of its transfer is done and one when the whole transfer is done. Each pulse sets a sticky pending bit. Software clears pending bits by writing ones to the status word. A second word of the same width holds per-bit enables. A single interrupt line is high while any bit is both pending and enabled.

Both words are reached through one small register port. A one-bit select chooses the word. Writes take effect on the clock edge, and reads return the selected word combinationally. An interrupt handler services completions lowest bit first. To support this, the block also decodes the lowest pending, enabled end-of-transfer bit into a channel group flag and a channel index.

The number of channels per group is a parameter. The status word holds four bits per channel slot: two bits for each normal channel and two for each dedicated channel.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status word, the enable word, `irq` and `end_valid` are all zero.
- R2: Bit mapping, with C = CH_PER_GROUP (8 by default). Normal channel i sets bit 2i on a half pulse and bit 2i+1 on an end pulse. Dedicated channel i sets bit 2C+2i on a half pulse and bit 2C+2i+1 on an end pulse. The new bit is readable after the clock edge that samples the pulse.
- R3: A pending bit stays set through idle cycles until software clears it.
- R4: A write with `reg_sel`=0 clears every status bit written as one and leaves the others unchanged. Writing all ones clears the whole word.
- R5: If an event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R6: Pending bits are set whether or not the matching enable bit is set.
- R7: A write with `reg_sel`=1 loads the enable word. A read with `reg_sel`=1 returns it, and a read with `reg_sel`=0 returns the status word.
- R8: `irq` is a register. After each edge it equals the OR over all bits of (status AND enable) as they stood before that edge, so it lags the status word by one cycle.
- R9: When any odd (end) bit is both pending and enabled, `end_valid` is 1 and the lowest such bit p is reported: `end_is_ded` = (p >= 2C) and `end_index` = (p/2) mod C. Pending end bits that are not enabled are never reported.
- R10: Half-transfer bits (even positions) never affect `end_valid`, `end_is_ded` or `end_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| norm_half_evt | input | CH_PER_GROUP | Half-transfer pulses, normal channels |
| norm_end_evt | input | CH_PER_GROUP | End-transfer pulses, normal channels |
| ded_half_evt | input | CH_PER_GROUP | Half-transfer pulses, dedicated channels |
| ded_end_evt | input | CH_PER_GROUP | End-transfer pulses, dedicated channels |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 4*CH_PER_GROUP | Write data |
| reg_rdata | output | 4*CH_PER_GROUP | Read data of the selected word |
| irq | output | 1 | Registered interrupt request |
| end_valid | output | 1 | A pending, enabled end bit exists |
| end_is_ded | output | 1 | The reported channel is dedicated (1) or normal (0) |
| end_index | output | clog2(CH_PER_GROUP) | Index of the reported channel within its group |

## Verification
The bench builds the block with the default of eight channels per group, which gives a full 32-bit word. With this width, tests reach the top bit (dedicated channel 7, end), the boundary between the groups at bits 15 and 16, and index wrap-around, where dedicated channel 1 reports index 1 just as normal channel 1 does. Directed tasks cover the collision of an event with a clear, the one-cycle lag of the interrupt, and the lowest-first order of the decoder while half bits and disabled bits are also pending.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants and helpers for the DMA interrupt status unit.
// Assumes channel groups of equal size; four status bits per channel slot.
package dma_irq_pkg;

    // Which group a decoded channel belongs to.
    typedef enum logic {
        GRP_NORMAL    = 1'b0,
        GRP_DEDICATED = 1'b1
    } ch_group_e;

    // Status bits owned by each channel (half, end).
    localparam int BITS_PER_CH = 2;

    // Width of the status word for a given group size.
    function automatic int word_width(input int ch_per_group);
        return 2 * BITS_PER_CH * ch_per_group;
    endfunction

endpackage

// File: rtl/dma_irq_event_map.sv
// Module: dma_irq_event_map
// Packs the per-channel half/end pulses of both groups into one word laid
// out as the status register: channel i of a group owns bits 2i (half) and
// 2i+1 (end); the dedicated group sits above the normal group.
// Assumes pulses are synchronous to the consuming clock.
module dma_irq_event_map #(
    parameter int CH_PER_GROUP = 8,
    localparam int WORD_W      = 4 * CH_PER_GROUP,
    localparam int HALF_W      = 2 * CH_PER_GROUP
) (
    input  logic [CH_PER_GROUP-1:0] norm_half,
    input  logic [CH_PER_GROUP-1:0] norm_end,
    input  logic [CH_PER_GROUP-1:0] ded_half,
    input  logic [CH_PER_GROUP-1:0] ded_end,
    output logic [WORD_W-1:0]       evt_word
);

    // One slot of four bits per channel index.
    for (genvar i = 0; i < CH_PER_GROUP; i++) begin : g_slot
        assign evt_word[2*i]            = norm_half[i];
        assign evt_word[2*i+1]          = norm_end[i];
        assign evt_word[HALF_W + 2*i]   = ded_half[i];
        assign evt_word[HALF_W + 2*i+1] = ded_end[i];
    end

endmodule

// File: rtl/dma_irq_pend_reg.sv
// Module: dma_irq_pend_reg
// Sticky pending bits. A set pulse marks a bit, a clear mask removes bits;
// when both touch a bit in one cycle the set wins so no event is lost.
// Assumes clr_word is already qualified by the write strobe.
module dma_irq_pend_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_word,
    input  logic [WORD_W-1:0] clr_word,
    output logic [WORD_W-1:0] pend_q
);

    logic [WORD_W-1:0] pend_d;

    // Next state: keep uncleared bits, then OR in new events.
    always_comb begin
        pend_d = (pend_q & ~clr_word) | set_word;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/dma_irq_enable_reg.sv
// Module: dma_irq_enable_reg
// Plain write-loaded enable word, reset to all zeros (nothing enabled).
// Assumes wr is already qualified by the register select.
module dma_irq_enable_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] en_q
);

    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            en_q <= wdata;
        end
    end

endmodule

// File: rtl/dma_irq_end_decoder.sv
// Module: dma_irq_end_decoder
// Finds the lowest odd (end-of-transfer) bit that is set in the active
// word and reports its group and channel index. Even bits are ignored.
// Assumes active_word = pending AND enable.
module dma_irq_end_decoder
    import dma_irq_pkg::*;
#(
    parameter int CH_PER_GROUP = 8,
    localparam int WORD_W      = 4 * CH_PER_GROUP,
    localparam int NUM_SLOTS   = 2 * CH_PER_GROUP,
    localparam int IDX_W       = (CH_PER_GROUP > 1) ? $clog2(CH_PER_GROUP) : 1
) (
    input  logic [WORD_W-1:0] active_word,
    output logic              found,
    output ch_group_e         group,
    output logic [IDX_W-1:0]  index
);

    logic [NUM_SLOTS-1:0] end_bits;

    // Gather only the end bits, one per channel slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_end
        assign end_bits[s] = active_word[2*s+1];
    end

    // Priority search from the lowest slot upwards.
    always_comb begin
        found = 1'b0;
        group = GRP_NORMAL;
        index = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (!found && end_bits[s]) begin
                found = 1'b1;
                if (s >= CH_PER_GROUP) begin
                    group = GRP_DEDICATED;
                    index = IDX_W'(s - CH_PER_GROUP);
                end else begin
                    group = GRP_NORMAL;
                    index = IDX_W'(s);
                end
            end
        end
    end

endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: dma_irq_ctrl (top)
// Interrupt status and mask unit for two groups of DMA channels. Collects
// half/end pulses into sticky pending bits (write-one-to-clear), holds an
// enable word, drives a registered interrupt and decodes the lowest
// pending, enabled end event. reg_sel=0 addresses the status word,
// reg_sel=1 the enable word; reads are combinational.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int CH_PER_GROUP = 8,
    localparam int WORD_W      = 4 * CH_PER_GROUP,
    localparam int IDX_W       = (CH_PER_GROUP > 1) ? $clog2(CH_PER_GROUP) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CH_PER_GROUP-1:0] norm_half_evt,
    input  logic [CH_PER_GROUP-1:0] norm_end_evt,
    input  logic [CH_PER_GROUP-1:0] ded_half_evt,
    input  logic [CH_PER_GROUP-1:0] ded_end_evt,
    input  logic                    reg_wr,
    input  logic                    reg_sel,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    output logic                    irq,
    output logic                    end_valid,
    output logic                    end_is_ded,
    output logic [IDX_W-1:0]        end_index
);

    logic [WORD_W-1:0] evt_word;
    logic [WORD_W-1:0] clr_word;
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] active_word;
    logic              en_wr;
    ch_group_e         dec_group;

    // Write strobes split by select.
    always_comb begin
        clr_word = (reg_wr && !reg_sel) ? reg_wdata : '0;
        en_wr    = reg_wr && reg_sel;
    end

    dma_irq_event_map #(
        .CH_PER_GROUP (CH_PER_GROUP)
    ) u_map (
        .norm_half (norm_half_evt),
        .norm_end  (norm_end_evt),
        .ded_half  (ded_half_evt),
        .ded_end   (ded_end_evt),
        .evt_word  (evt_word)
    );

    dma_irq_pend_reg #(
        .WORD_W (WORD_W)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_word (evt_word),
        .clr_word (clr_word),
        .pend_q   (pend_q)
    );

    dma_irq_enable_reg #(
        .WORD_W (WORD_W)
    ) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    // Bits that may raise an interrupt.
    always_comb begin
        active_word = pend_q & en_q;
    end

    dma_irq_end_decoder #(
        .CH_PER_GROUP (CH_PER_GROUP)
    ) u_dec (
        .active_word (active_word),
        .found       (end_valid),
        .group       (dec_group),
        .index       (end_index)
    );

    // Group flag to a plain output bit.
    always_comb begin
        end_is_ded = (dec_group == GRP_DEDICATED);
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |active_word;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = reg_sel ? en_q : pend_q;
    end

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Module: dma_irq_ctrl_chk
// Property checker bound to dma_irq_ctrl. Relates port activity to the
// status and enable words across clock edges.
module dma_irq_ctrl_chk #(
    parameter int CH_PER_GROUP = 8,
    localparam int WORD_W      = 4 * CH_PER_GROUP,
    localparam int HALF_W      = 2 * CH_PER_GROUP,
    localparam int IDX_W       = (CH_PER_GROUP > 1) ? $clog2(CH_PER_GROUP) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CH_PER_GROUP-1:0] norm_half_evt,
    input logic [CH_PER_GROUP-1:0] norm_end_evt,
    input logic [CH_PER_GROUP-1:0] ded_half_evt,
    input logic [CH_PER_GROUP-1:0] ded_end_evt,
    input logic                    reg_wr,
    input logic                    reg_sel,
    input logic [WORD_W-1:0]       reg_wdata,
    input logic                    irq,
    input logic                    end_valid,
    input logic                    end_is_ded,
    input logic [IDX_W-1:0]        end_index,
    input logic [WORD_W-1:0]       pend_q,
    input logic [WORD_W-1:0]       en_q
);

    logic [WORD_W-1:0] chk_evt;
    logic [WORD_W-1:0] chk_clr;
    int unsigned       chk_pos;

    // Expected event word and clear mask, rebuilt from ports.
    always_comb begin
        chk_evt = '0;
        for (int i = 0; i < CH_PER_GROUP; i++) begin
            chk_evt[2*i]            = norm_half_evt[i];
            chk_evt[2*i+1]          = norm_end_evt[i];
            chk_evt[HALF_W + 2*i]   = ded_half_evt[i];
            chk_evt[HALF_W + 2*i+1] = ded_end_evt[i];
        end
        chk_clr = (reg_wr && !reg_sel) ? reg_wdata : '0;
        chk_pos = (end_is_ded ? HALF_W : 0) + 2 * int'(end_index) + 1;
    end

    // R1: reset leaves both words and the interrupt cleared.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && !irq));

    // R3: a pending bit that was not cleared is still pending.
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(chk_clr)) & ~pend_q) == '0));

    // R5, R6: every event lands regardless of clear or enable.
    assert_event_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(chk_evt) & ~pend_q) == '0));

    // R8: the interrupt follows the masked status one cycle later.
    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(pend_q) & $past(en_q))));

    // R9: a reported end bit is pending and enabled.
    assert_decode_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid |-> (pend_q[chk_pos] && en_q[chk_pos]));

    // R9: nothing reported when no end bit is active.
    assert_decode_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q & {CH_PER_GROUP*2{2'b10}}) == '0) |-> !end_valid);

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
    .CH_PER_GROUP (CH_PER_GROUP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .norm_half_evt (norm_half_evt),
    .norm_end_evt  (norm_end_evt),
    .ded_half_evt  (ded_half_evt),
    .ded_end_evt   (ded_end_evt),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .irq           (irq),
    .end_valid     (end_valid),
    .end_is_ded    (end_is_ded),
    .end_index     (end_index),
    .pend_q        (pend_q),
    .en_q          (en_q)
);

// File: tb/dma_irq_ctrl_test.sv
// Directed bench for dma_irq_ctrl with eight channels per group.
module dma_irq_ctrl_test;

    localparam int C = 8;
    localparam int W = 4 * C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [C-1:0]  norm_half_evt = '0;
    logic [C-1:0]  norm_end_evt = '0;
    logic [C-1:0]  ded_half_evt = '0;
    logic [C-1:0]  ded_end_evt = '0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          irq;
    logic          end_valid;
    logic          end_is_ded;
    logic [2:0]    end_index;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    dma_irq_ctrl #(.CH_PER_GROUP(C)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .norm_half_evt (norm_half_evt),
        .norm_end_evt  (norm_end_evt),
        .ded_half_evt  (ded_half_evt),
        .ded_end_evt   (ded_end_evt),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .end_valid     (end_valid),
        .end_is_ded    (end_is_ded),
        .end_index     (end_index)
    );

    always #5 clk = ~clk;

    // One edge, then settle; inputs applied before the call are sampled.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(input logic sel, output logic [W-1:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic write_word(input logic sel, input logic [W-1:0] val);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = val;
        step();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic clear_all();
        write_word(1'b0, '1);
    endtask

    // R1: state after reset.
    task automatic t_reset();
        logic [W-1:0] v;
        read_word(1'b0, v);
        check("R1 status after reset", v, '0);
        read_word(1'b1, v);
        check("R1 enable after reset", v, '0);
        check("R1 irq after reset", W'(irq), '0);
        check("R1 end_valid after reset", W'(end_valid), '0);
    endtask

    // R2, R3, R6: bit positions, stickiness, enable-independent setting.
    task automatic t_mapping();
        logic [W-1:0] v;
        norm_half_evt[3] = 1'b1;
        step();
        norm_half_evt = '0;
        read_word(1'b0, v);
        check("R2 R6 normal ch3 half -> bit 6", v, W'(1) << 6);
        repeat (3) step();
        read_word(1'b0, v);
        check("R3 bit 6 still set after idle", v, W'(1) << 6);
        clear_all();
        norm_end_evt[5] = 1'b1;
        step();
        norm_end_evt = '0;
        read_word(1'b0, v);
        check("R2 normal ch5 end -> bit 11", v, W'(1) << 11);
        clear_all();
        ded_half_evt[0] = 1'b1;
        ded_end_evt[7] = 1'b1;
        step();
        ded_half_evt = '0;
        ded_end_evt = '0;
        read_word(1'b0, v);
        check("R2 dedicated ch0 half, ch7 end -> bits 16, 31", v, 32'h8001_0000);
        check("R6 irq stays low with enables zero", W'(irq), '0);
        clear_all();
    endtask

    // R4: write-one-to-clear.
    task automatic t_w1c();
        logic [W-1:0] v;
        norm_end_evt = 8'h81;
        ded_half_evt = 8'h02;
        step();
        norm_end_evt = '0;
        ded_half_evt = '0;
        read_word(1'b0, v);
        check("R4 setup pattern", v, 32'h0004_8002);
        write_word(1'b0, 32'h0000_8000);
        read_word(1'b0, v);
        check("R4 partial clear keeps other bits", v, 32'h0004_0002);
        write_word(1'b0, 32'h0000_0000);
        read_word(1'b0, v);
        check("R4 zero write changes nothing", v, 32'h0004_0002);
        clear_all();
        read_word(1'b0, v);
        check("R4 all-ones clears word", v, '0);
    endtask

    // R5: event and clear on the same bit in one cycle.
    task automatic t_collision();
        logic [W-1:0] v;
        norm_end_evt[2] = 1'b1;
        step();
        norm_end_evt[2] = 1'b1;
        norm_half_evt[0] = 1'b1;
        write_word(1'b0, 32'h0000_0021);
        norm_end_evt = '0;
        norm_half_evt = '0;
        read_word(1'b0, v);
        check("R5 set wins over clear (bits 5 and 0)", v, 32'h0000_0021);
        clear_all();
    endtask

    // R7, R8: enable word access and interrupt timing.
    task automatic t_irq();
        logic [W-1:0] v;
        write_word(1'b1, 32'h0100_0400);
        read_word(1'b1, v);
        check("R7 enable read back", v, 32'h0100_0400);
        read_word(1'b0, v);
        check("R7 select 0 returns status", v, '0);
        check("R8 enabled but not pending -> irq low", W'(irq), '0);
        norm_end_evt[4] = 1'b0;
        ded_half_evt[4] = 1'b1;
        step();
        ded_half_evt = '0;
        check("R8 irq still low in the cycle status sets", W'(irq), '0);
        step();
        check("R8 irq high one cycle later", W'(irq), 1);
        write_word(1'b0, 32'h0100_0000);
        check("R8 irq still high in the cycle status clears", W'(irq), 1);
        step();
        check("R8 irq low one cycle after clear", W'(irq), '0);
    endtask

    // R9, R10: lowest pending, enabled end bit.
    task automatic t_decoder();
        write_word(1'b1, 32'hFFFF_FFFF);
        norm_half_evt[0] = 1'b1;
        step();
        norm_half_evt = '0;
        check("R10 half bit alone -> end_valid low", W'(end_valid), '0);
        ded_end_evt[1] = 1'b1;
        norm_end_evt[6] = 1'b1;
        step();
        ded_end_evt = '0;
        norm_end_evt = '0;
        check("R9 end_valid with bits 13 and 19", W'(end_valid), 1);
        check("R9 lowest is normal group", W'(end_is_ded), '0);
        check("R9 lowest index 6", W'(end_index), 6);
        write_word(1'b0, 32'h0000_2000);
        check("R9 next is dedicated", W'(end_is_ded), 1);
        check("R9 dedicated index 1", W'(end_index), 1);
        write_word(1'b1, 32'h0000_0001);
        check("R9 disabled end bit not reported", W'(end_valid), '0);
        check("R10 half bit 0 keeps irq up without end report", W'(irq), 1);
        clear_all();
        write_word(1'b1, '0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_mapping();
        t_w1c();
        t_collision();
        t_irq();
        t_decoder();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule